// File: doc/BRIEF.md
# Opcode-Framed SPI Command Engine

This block carries out one command exchange with an external USB host controller chip over a four-wire SPI link in mode 0. A requester hands over an opcode, the number of parameter bytes that follow it, and the number of reply bytes expected. The block pulls chip select low once and keeps it low for the whole exchange. It shifts out the opcode, then streams the parameter bytes from a ready/valid input, then clocks 0xFF filler bytes while it captures the chip's reply. Each reply byte is handed back on a byte output with a one-cycle strobe. No frame size is fixed: every opcode decides its own lengths, and the requester supplies them.

The serial clock comes from a run-time divider of the system clock. A floor derived from the system and maximum serial frequencies keeps the serial clock below the chip's limit. Between exchanges, chip select stays high for at least two serial clock periods. The block also synchronises the chip's active-low interrupt line and emits a one-cycle event on every falling edge. It drives the chip's active-low reset pin.

Top module: `spi_cmd_engine`

## Requirements
- R1: While and after system reset, chip select is high, the serial clock is low, `busy_o`, `rsp_valid_o` and `irq_evt_o` are low, `req_ready_o` is high, and `chip_rst_n_o` is low during reset.
- R2: An accepted exchange asserts chip select exactly once. Under it, the block shifts the opcode first, then the `req_nparam_i` parameter bytes in the order they are accepted, then `req_nresp_i` bytes of 0xFF. Every byte goes most significant bit first.
- R3: Mode 0 timing applies: the serial clock idles low, MOSI changes only while the clock is low, and MISO is sampled on the rising edge. Exactly `req_nresp_i` reply bytes appear on `rsp_data_o`, in order, each with a one-cycle `rsp_valid_o`.
- R4: `par_ready_o` is high while the next parameter byte is awaited. Until `par_valid_i` is high, the serial clock stays low and chip select stays low.
- R5: `req_ready_o` is high only when the engine is idle. A request is taken on a cycle where `req_valid_i` and `req_ready_o` are both high, and requests offered during an exchange are held off.
- R6: A request whose opcode lies outside 0x01..0x6F is consumed by the handshake but starts no exchange: chip select stays high and no reply is produced.
- R7: `busy_o` equals the inverse of chip select; it rises in the cycle after acceptance. Between two exchanges, chip select is high for at least 4*(eff_div+1) system cycles, which is two serial periods.
- R8: Each serial clock half period lasts eff_div+1 system cycles, where eff_div = max(`div_i`, MIN_DIV). With defaults (250 MHz system clock, 12 MHz maximum), MIN_DIV is 10, so the half period is never shorter than 11 cycles.
- R9: Each falling edge on `chip_irq_n_i`, after a synchroniser of SYNC_STAGES flops, gives exactly one one-cycle `irq_evt_o` pulse. A rising edge gives none.
- R10: `chip_rst_n_o` goes low in the cycle after `chip_rst_req_i` is high and returns high in the cycle after it drops.
- R11: Counts are CNT_W bits wide (0 to 63 by default). A count of zero skips its phase, and an exchange of 63 reply bytes completes with all 63 delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Active-low asynchronous system reset |
| div_i | input | DIV_W | Requested half-period minus one, in system cycles |
| req_valid_i | input | 1 | Command request offered |
| req_ready_o | output | 1 | Engine idle and able to take a request |
| req_opcode_i | input | 8 | Opcode byte |
| req_nparam_i | input | CNT_W | Number of parameter bytes |
| req_nresp_i | input | CNT_W | Number of reply bytes |
| par_valid_i | input | 1 | Parameter byte offered |
| par_ready_o | output | 1 | Engine waiting for the next parameter byte |
| par_data_i | input | 8 | Parameter byte |
| rsp_valid_o | output | 1 | One-cycle strobe for a reply byte |
| rsp_data_o | output | 8 | Reply byte |
| busy_o | output | 1 | Exchange in progress (chip select low) |
| spi_cs_n_o | output | 1 | Active-low chip select |
| spi_sclk_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the chip |
| spi_miso_i | input | 1 | Serial data from the chip |
| chip_irq_n_i | input | 1 | Active-low interrupt from the chip |
| irq_evt_o | output | 1 | One-cycle pulse per interrupt falling edge |
| chip_rst_req_i | input | 1 | Request to hold the chip in reset |
| chip_rst_n_o | output | 1 | Active-low reset to the chip |

## Verification
The bench targets zero-length phases. A design that checks a count only after decrementing it would send a stray parameter byte or an extra filler byte, and the byte count under chip select would be wrong. It also stalls the parameter stream: a design that keeps toggling the clock while it waits would shift a stale byte, which shows up as clock activity during the stall and a corrupted parameter at the model. It drives back-to-back requests and illegal opcodes. A missing chip-select gap shows up as a high time shorter than two serial periods, and an unfiltered opcode as a spurious chip-select fall. It also sets a divider below the floor: if the clamp were missing, the measured clock high time would fall short of 11 cycles.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_PARAM,
      ST_TAIL,
      ST_GAP
   } eng_state_e;

   typedef enum logic [1:0] {
      BK_OPC,
      BK_PAR,
      BK_RSP
   } byte_kind_e;

   localparam logic [7:0] OPC_LOW  = 8'h01;
   localparam logic [7:0] OPC_HIGH = 8'h6F;
   localparam logic [7:0] FILLER   = 8'hFF;

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
   parameter int DIV_W   = 8,
   parameter int MIN_DIV = 10
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             clear_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] eff_div;
   logic [DIV_W-1:0] cnt_q;

   generate
      if (MIN_DIV > 0) begin : g_clamp
         always_comb eff_div = (div_i < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_i;
      end else begin : g_direct
         always_comb eff_div = div_i;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else if (clear_i) begin
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else if (cnt_q >= eff_div) begin
         cnt_q  <= '0;
         tick_o <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         tick_o <= 1'b0;
      end
   end

   // R8: a tick is never followed directly by another while the floor is nonzero
   generate
      if (MIN_DIV > 0) begin : g_chk
         a_r8_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            tick_o |=> !tick_o);
      end
   endgenerate
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
   parameter int WORD_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              tick_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] load_word_i,
   input  logic              miso_i,
   output logic              sclk_o,
   output logic              mosi_o,
   output logic              active_o,
   output logic              done_o,
   output logic [WORD_W-1:0] rx_word_o
);
   localparam int BIT_W = $clog2(WORD_W);

   logic [WORD_W-1:0] tx_q;
   logic [BIT_W-1:0]  bit_q;

   assign mosi_o = tx_q[WORD_W-1];

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         tx_q      <= '1;
         bit_q     <= '0;
         sclk_o    <= 1'b0;
         active_o  <= 1'b0;
         done_o    <= 1'b0;
         rx_word_o <= '0;
      end else begin
         done_o <= 1'b0;
         if (load_i) begin
            tx_q     <= load_word_i;
            bit_q    <= '0;
            sclk_o   <= 1'b0;
            active_o <= 1'b1;
         end else if (active_o && tick_i) begin
            if (!sclk_o) begin
               sclk_o    <= 1'b1;
               rx_word_o <= {rx_word_o[WORD_W-2:0], miso_i};
            end else begin
               sclk_o <= 1'b0;
               if (bit_q == BIT_W'(WORD_W-1)) begin
                  active_o <= 1'b0;
                  done_o   <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  tx_q  <= {tx_q[WORD_W-2:0], 1'b1};
               end
            end
         end
      end
   end

   // R3: data out is held steady for as long as the clock is high
   a_r3_mosi_steady: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      sclk_o |-> $stable(mosi_o));
   // R3: the clock only runs while a byte is in flight
   a_r3_clock_in_byte: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !active_o |-> !sclk_o);
endmodule

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic irq_n_i,
   output logic evt_o
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_n_i)
               if (!rst_n_i) sync_q[s] <= 1'b1;
               else          sync_q[s] <= irq_n_i;
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_n_i)
               if (!rst_n_i) sync_q[s] <= 1'b1;
               else          sync_q[s] <= sync_q[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         last_q <= 1'b1;
         evt_o  <= 1'b0;
      end else begin
         last_q <= sync_q[STAGES-1];
         evt_o  <= last_q && !sync_q[STAGES-1];
      end
   end

   // R9: every event is a single-cycle pulse
   a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      evt_o |=> !evt_o);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter int SYS_CLK_HZ   = 250_000_000,
   parameter int MAX_SCLK_HZ  = 12_000_000,
   parameter int DIV_W        = 8,
   parameter int CNT_W        = 6,
   parameter int CS_GAP_SCLK  = 2,
   parameter int SYNC_STAGES  = 2
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             req_valid_i,
   output logic             req_ready_o,
   input  logic [7:0]       req_opcode_i,
   input  logic [CNT_W-1:0] req_nparam_i,
   input  logic [CNT_W-1:0] req_nresp_i,
   input  logic             par_valid_i,
   output logic             par_ready_o,
   input  logic [7:0]       par_data_i,
   output logic             rsp_valid_o,
   output logic [7:0]       rsp_data_o,
   output logic             busy_o,
   output logic             spi_cs_n_o,
   output logic             spi_sclk_o,
   output logic             spi_mosi_o,
   input  logic             spi_miso_i,
   input  logic             chip_irq_n_i,
   output logic             irq_evt_o,
   input  logic             chip_rst_req_i,
   output logic             chip_rst_n_o
);
   localparam int HALF_MIN  = (SYS_CLK_HZ + 2*MAX_SCLK_HZ - 1) / (2*MAX_SCLK_HZ);
   localparam int MIN_DIV   = (HALF_MIN > 0) ? HALF_MIN - 1 : 0;
   localparam int GAP_TICKS = 2 * CS_GAP_SCLK;
   localparam int GAP_W     = $clog2(GAP_TICKS + 1);

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (MIN_DIV >= (1 << DIV_W)) begin : g_bad_div
         $error("DIV_W too narrow for the serial clock floor");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CS_GAP_SCLK < 1) begin : g_bad_gap
         $error("CS_GAP_SCLK must be at least 1");
      end
   endgenerate

   eng_state_e       state_q;
   byte_kind_e       kind_q;
   logic [7:0]       op_q;
   logic [CNT_W-1:0] np_q, nr_q;
   logic [GAP_W-1:0] gap_q;

   logic       tick, tick_clr, ld;
   logic [7:0] ld_word, rx_word;
   logic       sh_active, sh_done;
   logic       opc_ok, accept;

   assign req_ready_o = (state_q == ST_IDLE);
   assign opc_ok      = (req_opcode_i >= OPC_LOW) && (req_opcode_i <= OPC_HIGH);
   assign accept      = req_valid_i && req_ready_o;
   assign busy_o      = !spi_cs_n_o;
   assign tick_clr    = ld || (state_q == ST_IDLE);

   always_comb begin
      ld          = 1'b0;
      ld_word     = FILLER;
      par_ready_o = 1'b0;
      case (state_q)
         ST_LEAD: begin
            ld      = tick;
            ld_word = op_q;
         end
         ST_SHIFT: ld = sh_done && (np_q == '0) && (nr_q != '0);
         ST_PARAM: begin
            par_ready_o = 1'b1;
            ld          = par_valid_i;
            ld_word     = par_data_i;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         state_q     <= ST_IDLE;
         kind_q      <= BK_OPC;
         op_q        <= '0;
         np_q        <= '0;
         nr_q        <= '0;
         gap_q       <= '0;
         spi_cs_n_o  <= 1'b1;
         rsp_valid_o <= 1'b0;
         rsp_data_o  <= '0;
      end else begin
         rsp_valid_o <= 1'b0;
         case (state_q)
            ST_IDLE: if (accept && opc_ok) begin
               spi_cs_n_o <= 1'b0;
               op_q       <= req_opcode_i;
               np_q       <= req_nparam_i;
               nr_q       <= req_nresp_i;
               state_q    <= ST_LEAD;
            end
            ST_LEAD: if (tick) begin
               kind_q  <= BK_OPC;
               state_q <= ST_SHIFT;
            end
            ST_SHIFT: if (sh_done) begin
               if (kind_q == BK_RSP) begin
                  rsp_valid_o <= 1'b1;
                  rsp_data_o  <= rx_word;
               end
               if (np_q != '0) begin
                  state_q <= ST_PARAM;
               end else if (nr_q != '0) begin
                  nr_q   <= nr_q - 1'b1;
                  kind_q <= BK_RSP;
               end else begin
                  state_q <= ST_TAIL;
               end
            end
            ST_PARAM: if (par_valid_i) begin
               np_q    <= np_q - 1'b1;
               kind_q  <= BK_PAR;
               state_q <= ST_SHIFT;
            end
            ST_TAIL: if (tick) begin
               spi_cs_n_o <= 1'b1;
               gap_q      <= '0;
               state_q    <= ST_GAP;
            end
            ST_GAP: if (tick) begin
               if (gap_q == GAP_W'(GAP_TICKS - 1)) state_q <= ST_IDLE;
               else                                gap_q   <= gap_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) chip_rst_n_o <= 1'b0;
      else          chip_rst_n_o <= !chip_rst_req_i;
   end

   spi_tick_gen #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) tick_i (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .clear_i (tick_clr),
      .div_i   (div_i),
      .tick_o  (tick)
   );

   spi_byte_shift #(.WORD_W(8)) shift_i (
      .clk_i       (clk_i),
      .rst_n_i     (rst_n_i),
      .tick_i      (tick),
      .load_i      (ld),
      .load_word_i (ld_word),
      .miso_i      (spi_miso_i),
      .sclk_o      (spi_sclk_o),
      .mosi_o      (spi_mosi_o),
      .active_o    (sh_active),
      .done_o      (sh_done),
      .rx_word_o   (rx_word)
   );

   irq_edge_sync #(.STAGES(SYNC_STAGES)) irq_i (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .irq_n_i (chip_irq_n_i),
      .evt_o   (irq_evt_o)
   );

   // R2: bytes are only shifted while chip select is asserted
   a_r2_shift_under_cs: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      sh_active |-> !spi_cs_n_o);
   // R3: serial clock rests low whenever chip select is released
   a_r3_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      spi_cs_n_o |-> !spi_sclk_o);
   // R3: reply strobes fall inside the chip-select window
   a_r3_rsp_in_frame: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      rsp_valid_o |-> !spi_cs_n_o);
   // R4: the clock is parked low while a parameter byte is awaited
   a_r4_stall_parked: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      par_ready_o |-> (!spi_sclk_o && !spi_cs_n_o));
   // R5: no request is taken during an exchange
   a_r5_refuse_busy: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      busy_o |-> !req_ready_o);
   // R6: an illegal opcode never pulls chip select low
   a_r6_bad_opcode: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (accept && !opc_ok) |=> spi_cs_n_o);
endmodule

// File: tb/spi_cmd_engine_tb_top.sv
module spi_cmd_engine_tb_top;
   localparam int CNT_W = 6;
   localparam int DIV_W = 8;

   logic             clk_i = 1'b0;
   logic             rst_n_i = 1'b0;
   logic [DIV_W-1:0] div_i = 8'd11;
   logic             req_valid_i = 1'b0;
   logic             req_ready_o;
   logic [7:0]       req_opcode_i = '0;
   logic [CNT_W-1:0] req_nparam_i = '0;
   logic [CNT_W-1:0] req_nresp_i = '0;
   logic             par_valid_i;
   logic             par_ready_o;
   logic [7:0]       par_data_i;
   logic             rsp_valid_o;
   logic [7:0]       rsp_data_o;
   logic             busy_o;
   logic             spi_cs_n_o, spi_sclk_o, spi_mosi_o;
   logic             spi_miso_i = 1'b1;
   logic             chip_irq_n_i = 1'b1;
   logic             irq_evt_o;
   logic             chip_rst_req_i = 1'b0;
   logic             chip_rst_n_o;

   always #2 clk_i = ~clk_i;

   spi_cmd_engine dut_i (
      .clk_i, .rst_n_i, .div_i, .req_valid_i, .req_ready_o, .req_opcode_i,
      .req_nparam_i, .req_nresp_i, .par_valid_i, .par_ready_o, .par_data_i,
      .rsp_valid_o, .rsp_data_o, .busy_o, .spi_cs_n_o, .spi_sclk_o, .spi_mosi_o,
      .spi_miso_i, .chip_irq_n_i, .irq_evt_o, .chip_rst_req_i, .chip_rst_n_o
   );

   int errs = 0, checks = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int j);
      return 8'h5A ^ 8'(j * 29);
   endfunction

   // ---------------- parameter feeder ----------------
   logic [7:0] prm [0:63];
   int feed_np = 0, stall_cfg = 0;
   int pidx = 0, stall_ctr = 0;
   bit feed_rst = 0;
   assign par_valid_i = (pidx < feed_np) && (stall_ctr == 0);
   assign par_data_i  = prm[pidx[5:0]];
   always @(posedge clk_i) begin
      if (feed_rst) begin
         pidx      <= 0;
         stall_ctr <= stall_cfg;
      end else if (par_ready_o && par_valid_i) begin
         pidx      <= pidx + 1;
         stall_ctr <= stall_cfg;
      end else if (par_ready_o && stall_ctr != 0) begin
         stall_ctr <= stall_ctr - 1;
      end
   end

   // ---------------- chip model ----------------
   logic [7:0] mon_buf [0:1023];
   int mon_total = 0, cs_falls = 0, fidx = 0, bitc = 0;
   logic [7:0] shreg = '0;
   logic cs_prev = 1'b1, sclk_prev = 1'b0;
   always @(spi_cs_n_o or spi_sclk_o) begin
      if (!spi_cs_n_o && cs_prev) begin
         fidx = 0; bitc = 0; cs_falls++;
         spi_miso_i = pat(0)[7];
      end else if (!spi_cs_n_o && spi_sclk_o && !sclk_prev) begin
         shreg = {shreg[6:0], spi_mosi_o};
         bitc++;
         if (bitc == 8) begin
            mon_buf[mon_total[9:0]] = shreg;
            mon_total++; fidx++; bitc = 0;
         end
      end else if (!spi_cs_n_o && !spi_sclk_o && sclk_prev) begin
         spi_miso_i = pat(fidx)[7 - bitc];
      end
      cs_prev = spi_cs_n_o;
      sclk_prev = spi_sclk_o;
   end

   // ---------------- output monitors ----------------
   logic [7:0] rsp_buf [0:511];
   int rsp_total = 0, stall_cyc = 0, stall_bad = 0, busy_mis = 0;
   int hi_run = 0, last_hi = 0, cs_run = 0, last_gap = 0, evt_cnt = 0;
   always @(negedge clk_i) begin
      if (rst_n_i) begin
         if (rsp_valid_o) begin
            rsp_buf[rsp_total[8:0]] = rsp_data_o;
            rsp_total++;
         end
         if (par_ready_o && !par_valid_i) stall_cyc++;
         if (par_ready_o && (spi_sclk_o || spi_cs_n_o)) stall_bad++;
         if (busy_o != !spi_cs_n_o) busy_mis++;
         if (irq_evt_o) evt_cnt++;
         if (spi_sclk_o) hi_run++;
         else begin
            if (hi_run > 0) last_hi = hi_run;
            hi_run = 0;
         end
         if (spi_cs_n_o) cs_run++;
         else begin
            if (cs_run > 0) last_gap = cs_run;
            cs_run = 0;
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic do_req(input logic [7:0] op, input int np, input int nr);
      @(negedge clk_i);
      req_opcode_i = op;
      req_nparam_i = CNT_W'(np);
      req_nresp_i  = CNT_W'(nr);
      req_valid_i  = 1'b1;
      forever begin
         @(posedge clk_i);
         if (req_ready_o) break;
      end
      @(negedge clk_i);
      req_valid_i = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk_i); while (!req_ready_o);
   endtask

   task automatic setup_feed(input int np, input int stall);
      for (int i = 0; i < 64; i++) prm[i] = 8'h30 + 8'(i * 7);
      @(negedge clk_i);
      feed_np = np; stall_cfg = stall; feed_rst = 1;
      @(negedge clk_i);
      feed_rst = 0;
   endtask

   // full exchange with byte-level checks
   task automatic run_txn(input logic [7:0] op, input int np, input int nr,
                          input int stall, input string tag);
      int mb, rb, cf, sb, bm;
      bit ok;
      setup_feed(np, stall);
      mb = mon_total; rb = rsp_total; cf = cs_falls; sb = stall_bad; bm = busy_mis;
      do_req(op, np, nr);
      wait_idle();
      chk(cs_falls - cf == 1, {tag, " R2 one chip-select frame"}, cs_falls - cf, 1);
      chk(mon_total - mb == 1 + np + nr, {tag, " R2 byte count"}, mon_total - mb, 1 + np + nr);
      chk(mon_buf[mb[9:0]] == op, {tag, " R2 opcode first"}, mon_buf[mb[9:0]], op);
      ok = 1;
      for (int i = 0; i < np; i++) if (mon_buf[(mb + 1 + i) % 1024] != prm[i]) ok = 0;
      chk(ok, {tag, " R2 parameter bytes in order"}, ok, 1);
      ok = 1;
      for (int i = 0; i < nr; i++) if (mon_buf[(mb + 1 + np + i) % 1024] != 8'hFF) ok = 0;
      chk(ok, {tag, " R2 filler bytes"}, ok, 1);
      chk(rsp_total - rb == nr, {tag, " R3 reply count"}, rsp_total - rb, nr);
      ok = 1;
      for (int i = 0; i < nr; i++) if (rsp_buf[(rb + i) % 512] != pat(1 + np + i)) ok = 0;
      chk(ok, {tag, " R3 reply bytes"}, ok, 1);
      chk(busy_mis == bm, {tag, " R7 busy tracks chip select"}, busy_mis - bm, 0);
      chk(stall_bad == sb, {tag, " R4 clock parked in stall"}, stall_bad - sb, 0);
   endtask

   task automatic t_reset();
      chk(chip_rst_n_o == 1'b0, "R1 R10 chip reset low during reset", chip_rst_n_o, 0);
      @(negedge clk_i); rst_n_i = 1'b1;
      @(negedge clk_i);
      chk(spi_cs_n_o == 1'b1, "R1 chip select high", spi_cs_n_o, 1);
      chk(spi_sclk_o == 1'b0, "R1 clock low", spi_sclk_o, 0);
      chk(busy_o == 1'b0 && rsp_valid_o == 1'b0 && irq_evt_o == 1'b0,
          "R1 busy/strobes low", busy_o, 0);
      chk(req_ready_o == 1'b1, "R1 ready after reset", req_ready_o, 1);
      chk(chip_rst_n_o == 1'b1, "R1 chip reset released", chip_rst_n_o, 1);
   endtask

   task automatic t_lengths();
      div_i = 8'd11;
      run_txn(8'h06, 0, 0, 0, "R11 opcode only");
      run_txn(8'h15, 1, 0, 0, "R2 params only");
      run_txn(8'h22, 0, 4, 0, "R3 reply only");
      run_txn(8'h53, 5, 3, 0, "R2 mixed");
      run_txn(8'h6F, 2, 1, 0, "R2 top opcode");
      run_txn(8'h01, 0, 63, 0, "R11 max replies");
      chk(last_hi == 12, "R8 half period with div 11", last_hi, 12);
   endtask

   task automatic t_stall();
      int sc;
      sc = stall_cyc;
      run_txn(8'h2C, 3, 1, 40, "R4 stalled params");
      chk(stall_cyc - sc >= 120, "R4 stall observed", stall_cyc - sc, 120);
   endtask

   task automatic t_busy();
      int cf;
      cf = cs_falls;
      setup_feed(0, 0);
      do_req(8'h27, 0, 3);
      @(negedge clk_i);
      req_valid_i = 1'b1; req_opcode_i = 8'h06;
      req_nparam_i = '0; req_nresp_i = '0;
      repeat (100) @(negedge clk_i);
      chk(busy_o == 1'b1, "R7 busy during exchange", busy_o, 1);
      chk(req_ready_o == 1'b0, "R5 request held off", req_ready_o, 0);
      req_valid_i = 1'b0;
      wait_idle();
      chk(cs_falls - cf == 1, "R5 refused request not started", cs_falls - cf, 1);
   endtask

   task automatic t_gap();
      setup_feed(0, 0);
      do_req(8'h06, 0, 1);
      do_req(8'h06, 0, 1);
      wait_idle();
      chk(last_gap >= 48, "R7 chip-select gap", last_gap, 48);
   endtask

   task automatic t_bad_opcode();
      int cf, rb;
      cf = cs_falls; rb = rsp_total;
      do_req(8'h00, 1, 2);
      do_req(8'h70, 0, 2);
      repeat (100) @(negedge clk_i);
      chk(cs_falls == cf, "R6 illegal opcodes start nothing", cs_falls - cf, 0);
      chk(rsp_total == rb && req_ready_o, "R6 no reply, still ready", rsp_total - rb, 0);
   endtask

   task automatic t_clamp();
      div_i = 8'd0;
      run_txn(8'h45, 0, 1, 0, "R8 clamped");
      chk(last_hi == 11, "R8 floor half period", last_hi, 11);
      div_i = 8'd20;
      run_txn(8'h45, 0, 1, 0, "R8 slow");
      chk(last_hi == 21, "R8 half period with div 20", last_hi, 21);
      div_i = 8'd11;
   endtask

   task automatic t_irq();
      int ec;
      ec = evt_cnt;
      @(negedge clk_i); chip_irq_n_i = 1'b0;
      repeat (10) @(negedge clk_i);
      chk(evt_cnt - ec == 1, "R9 one pulse per falling edge", evt_cnt - ec, 1);
      ec = evt_cnt;
      chip_irq_n_i = 1'b1;
      repeat (10) @(negedge clk_i);
      chk(evt_cnt == ec, "R9 no pulse on rising edge", evt_cnt - ec, 0);
      chip_irq_n_i = 1'b0;
      repeat (10) @(negedge clk_i);
      chk(evt_cnt - ec == 1, "R9 second falling edge", evt_cnt - ec, 1);
      chip_irq_n_i = 1'b1;
   endtask

   task automatic t_chip_reset();
      @(negedge clk_i); chip_rst_req_i = 1'b1;
      @(negedge clk_i);
      chk(chip_rst_n_o == 1'b0, "R10 chip reset asserted", chip_rst_n_o, 0);
      chip_rst_req_i = 1'b0;
      @(negedge clk_i);
      chk(chip_rst_n_o == 1'b1, "R10 chip reset released", chip_rst_n_o, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      t_reset();
      t_lengths();
      t_stall();
      t_busy();
      t_gap();
      t_bad_opcode();
      t_clamp();
      t_irq();
      t_chip_reset();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!finished) begin
         finished = 1;
         checks++; errs++;
         $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule